// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block serves one PHY register read or write request at a time. A request names a PHY number, a page, a register number and, for a write, a 16-bit value. The block turns that request into a short series of single-register transactions on the register-access port of a switch. It drives that port as a request that is held until a response arrives, and a management bus master, outside this block, carries each transaction on the wire.

A PHY register is not addressed directly. The block first writes a direction code into a fixed control register. It then writes to an indirect address made from a base value, a one-hot PHY select field, the page and the register number. For a read, a third transaction fetches the result from a fixed data register. When asked, a write is followed by a full read sequence to the same PHY register so that the write is flushed. Requests with fields out of range are rejected before any traffic is generated. Any failed transaction ends the sequence early.

Top module: `phy_indirect_seq`

## Requirements
- R1: After reset, busy, done and busReqValid are all low, and no transaction is issued until a request arrives.
- R2: A request whose PHY number exceeds 4, whose page exceeds 7 or whose register exceeds 31 issues no transaction. It ends with done, respStatus = 1 (invalid argument) and respData = 0xFFFF.
- R3: The first transaction of every accepted request is a write to address 0x8028, with data 1 for a read and data 0 for a write.
- R4: The second transaction is a write to address 0x8000 | (1 << (9 + PHY)) | (page << 5) | register. The PHY select bits [13:9] therefore hold exactly one set bit.
- R5: For a read, the second transaction carries data 0. The third is a read of address 0x8029. Its returned data appears on respData with respStatus = 0.
- R6: For a write without flush, the second transaction carries the request's write data and is the last one. respStatus is 0 and respData is 0xFFFF.
- R7: A transaction that responds with an error stops the sequence, so no further transaction is issued. The request ends with respStatus = 2 (bus error) and respData = 0xFFFF.
- R8: A write with reqFlush set is followed by the full read sequence of R3 to R5 for the same PHY register. A bus error during that read ends the sequence but is not reported. respStatus reflects only the write, and respData is 0xFFFF.
- R9: A request is taken when reqValid is high and busy is low. Busy is high from the next cycle until the end of a one-cycle done pulse. reqValid while busy is ignored.
- R10: While busReqValid is high and no response has come, busReqValid, busReqAddr, busReqData and busReqWrite stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqWrite | input | 1 | 1 = PHY register write, 0 = read |
| reqFlush | input | 1 | For writes, follow up with a read of the same register |
| reqPhy | input | 5 | PHY number |
| reqPage | input | 4 | Page number |
| reqReg | input | 6 | PHY register number |
| reqWdata | input | 16 | Write value |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| respStatus | output | 2 | 0 ok, 1 invalid argument, 2 bus error |
| respData | output | 16 | Read result, 0xFFFF when none |
| busReqValid | output | 1 | Register transaction requested |
| busReqWrite | output | 1 | 1 = register write, 0 = register read |
| busReqAddr | output | 16 | Switch register address |
| busReqData | output | 16 | Switch register write data |
| busRespValid | input | 1 | Transaction complete, one cycle |
| busRespErr | input | 1 | Transaction failed |
| busRespData | input | 16 | Register read data |

## Verification
The bench sweeps every PHY number 0 to 5, every page 0 to 8 and every register 0 to 33, in both directions. This separates accepted requests from rejected ones at each field boundary, and it shows whether the one-hot select, the page bits and the register bits land in their own positions of the indirect address. A bus error is injected at each position of the read, write and flushed-write sequences. This tells apart an error that must abort and be reported from one in the flush read that must be swallowed. A request raised while the block is busy, and a response latency of several cycles, check that the block ignores the extra request and holds the bus request steady.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    TXN_CTRL = 2'd0,
    TXN_ADDR = 2'd1,
    TXN_DATA = 2'd2
  } txn_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_INVAL  = 2'd1,
    ST_BUSERR = 2'd2
  } status_e;

  typedef struct packed {
    logic load;       // latch request, clear result
    logic capture;    // store read data
    logic setInval;   // mark request rejected
    logic setBusErr;  // mark bus failure
    logic flushPh;    // flush read phase active
    txn_e txn;        // which transaction is on the port
  } strobes_t;

endpackage

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqOk,
  input  logic     curWrite,
  input  logic     curFlush,
  input  logic     busRespValid,
  input  logic     busRespErr,
  output strobes_t strb,
  output logic     busReqValid,
  output logic     busy,
  output logic     done
);

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_ADDR, S_DATA, S_FCTRL, S_FADDR, S_FDATA, S_FIN
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.txn  = TXN_CTRL;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        if (reqOk) nextState = S_CTRL;
        else begin
          strb.setInval = 1'b1;
          nextState     = S_FIN;
        end
      end
      S_CTRL: if (busRespValid) begin
        if (busRespErr) begin strb.setBusErr = 1'b1; nextState = S_FIN; end
        else nextState = S_ADDR;
      end
      S_ADDR: begin
        strb.txn = TXN_ADDR;
        if (busRespValid) begin
          if (busRespErr) begin strb.setBusErr = 1'b1; nextState = S_FIN; end
          else if (!curWrite) nextState = S_DATA;
          else nextState = curFlush ? S_FCTRL : S_FIN;
        end
      end
      S_DATA: begin
        strb.txn = TXN_DATA;
        if (busRespValid) begin
          if (busRespErr) strb.setBusErr = 1'b1;
          else            strb.capture   = 1'b1;
          nextState = S_FIN;
        end
      end
      S_FCTRL: begin
        strb.flushPh = 1'b1;
        if (busRespValid) nextState = busRespErr ? S_FIN : S_FADDR;
      end
      S_FADDR: begin
        strb.flushPh = 1'b1;
        strb.txn     = TXN_ADDR;
        if (busRespValid) nextState = busRespErr ? S_FIN : S_FDATA;
      end
      S_FDATA: begin
        strb.flushPh = 1'b1;
        strb.txn     = TXN_DATA;
        if (busRespValid) nextState = S_FIN;
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign busReqValid = busy && (state != S_FIN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
  // R2
  inval_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !reqOk) |=> (done && !busReqValid));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busRespValid) |=> busReqValid);

endmodule

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PHY_W      = 5,
  parameter int PAGE_W     = 4,
  parameter int REG_W      = 6,
  parameter int MAX_PHY    = 4,
  parameter int MAX_PAGE   = 7,
  parameter int MAX_REG    = 31,
  parameter int PHY_SHIFT  = 9,
  parameter int PAGE_SHIFT = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              reqWrite,
  input  logic              reqFlush,
  input  logic [PHY_W-1:0]  reqPhy,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRespData,
  output logic              reqOk,
  output logic              curWrite,
  output logic              curFlush,
  output logic              busReqWrite,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  output logic [1:0]        respStatus,
  output logic [DATA_W-1:0] respData
);

  localparam int PHY_CNT = MAX_PHY + 1;
  localparam int PAGE_FW = $clog2(MAX_PAGE + 1);
  localparam int REG_FW  = $clog2(MAX_REG + 1);

  logic [PHY_W-1:0]  curPhy;
  logic [PAGE_W-1:0] curPage;
  logic [REG_W-1:0]  curReg;
  logic [DATA_W-1:0] curWdata;
  logic [PHY_CNT-1:0] phyHot;
  logic [ADDR_W-1:0] indAddr;
  status_e           status;
  logic              isRead;

  assign reqOk = (int'(reqPhy) <= MAX_PHY) && (int'(reqPage) <= MAX_PAGE) &&
                 (int'(reqReg) <= MAX_REG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curFlush <= 1'b0;
      curPhy   <= '0;
      curPage  <= '0;
      curReg   <= '0;
      curWdata <= '0;
      status   <= ST_OK;
      respData <= '1;
    end else begin
      if (strb.load) begin
        curWrite <= reqWrite;
        curFlush <= reqFlush;
        curPhy   <= reqPhy;
        curPage  <= reqPage;
        curReg   <= reqReg;
        curWdata <= reqWdata;
        status   <= strb.setInval ? ST_INVAL : ST_OK;
        respData <= '1;
      end
      if (strb.setBusErr) status   <= ST_BUSERR;
      if (strb.capture)   respData <= busRespData;
    end
  end

  for (genvar g = 0; g < PHY_CNT; g++) begin : g_phySel
    assign phyHot[g] = (curPhy == PHY_W'(g));
  end

  assign indAddr = BASE_ADDR | (ADDR_W'(phyHot) << PHY_SHIFT) |
                   (ADDR_W'(curPage[PAGE_FW-1:0]) << PAGE_SHIFT) |
                   ADDR_W'(curReg[REG_FW-1:0]);

  assign isRead = !curWrite || strb.flushPh;

  always_comb begin
    busReqWrite = 1'b1;
    busReqAddr  = CTRL_ADDR;
    busReqData  = isRead ? DATA_W'(1) : '0;
    unique case (strb.txn)
      TXN_ADDR: begin
        busReqAddr = indAddr;
        busReqData = isRead ? '0 : curWdata;
      end
      TXN_DATA: begin
        busReqWrite = 1'b0;
        busReqAddr  = DATA_ADDR;
        busReqData  = '0;
      end
      default: ;
    endcase
  end

  assign respStatus = status;

  // R4
  phy_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txn == TXN_ADDR) |-> $onehot(busReqAddr[PHY_SHIFT +: PHY_CNT]));
  // R7
  err_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respStatus == ST_BUSERR) |-> (respData == '1));

endmodule

// File: rtl/phy_indirect_seq.sv
module phy_indirect_seq
  import phy_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int PHY_W  = 5,
  parameter int PAGE_W = 4,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqFlush,
  input  logic [PHY_W-1:0]  reqPhy,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        respStatus,
  output logic [DATA_W-1:0] respData,
  output logic              busReqValid,
  output logic              busReqWrite,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busRespValid,
  input  logic              busRespErr,
  input  logic [DATA_W-1:0] busRespData
);

  strobes_t strb;
  logic     reqOk, curWrite, curFlush;

  phy_seq_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOk        (reqOk),
    .curWrite     (curWrite),
    .curFlush     (curFlush),
    .busRespValid (busRespValid),
    .busRespErr   (busRespErr),
    .strb         (strb),
    .busReqValid  (busReqValid),
    .busy         (busy),
    .done         (done)
  );

  phy_seq_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PHY_W  (PHY_W),
    .PAGE_W (PAGE_W),
    .REG_W  (REG_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqWrite    (reqWrite),
    .reqFlush    (reqFlush),
    .reqPhy      (reqPhy),
    .reqPage     (reqPage),
    .reqReg      (reqReg),
    .reqWdata    (reqWdata),
    .busRespData (busRespData),
    .reqOk       (reqOk),
    .curWrite    (curWrite),
    .curFlush    (curFlush),
    .busReqWrite (busReqWrite),
    .busReqAddr  (busReqAddr),
    .busReqData  (busReqData),
    .respStatus  (respStatus),
    .respData    (respData)
  );

  // R10
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busRespValid) |=>
      ($stable(busReqAddr) && $stable(busReqData) && $stable(busReqWrite)));

endmodule

// File: tb/test_phy_indirect_seq.sv
module test_phy_indirect_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqFlush = 1'b0;
  logic [4:0]  reqPhy = '0;
  logic [3:0]  reqPage = '0;
  logic [5:0]  reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done, busReqValid, busReqWrite;
  logic [1:0]  respStatus;
  logic [15:0] respData, busReqAddr, busReqData;
  logic        busRespValid = 1'b0, busRespErr = 1'b0;
  logic [15:0] busRespData = '0;

  int tests = 0, fails = 0, cycles = 0;
  int txnIdx = 0, waitCnt = 0;
  int errAbs = -1, lat = 0;
  logic [15:0] rdVal = '0;
  logic        logWr[16];
  logic [15:0] logAddr[16], logData[16];

  always #2 clk = ~clk;

  phy_indirect_seq i_phy_indirect_seq (.*);

  // bus responder model
  always @(posedge clk) begin
    busRespValid <= 1'b0;
    if (busReqValid && !busRespValid) begin
      if (waitCnt >= lat) begin
        logWr[txnIdx % 16]   <= busReqWrite;
        logAddr[txnIdx % 16] <= busReqAddr;
        logData[txnIdx % 16] <= busReqData;
        busRespValid <= 1'b1;
        busRespErr   <= (txnIdx == errAbs);
        busRespData  <= rdVal;
        txnIdx  <= txnIdx + 1;
        waitCnt <= 0;
      end else waitCnt <= waitCnt + 1;
    end
  end

  task automatic check(input string tag, input logic ok, input logic [31:0] got,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic doOp(input logic w, input logic [4:0] phy, input logic [3:0] pg,
                      input logic [5:0] rg, input logic [15:0] wd, input logic fl,
                      input int errRel, input logic [15:0] rv, input logic midReq);
    int startIdx, n, mainLen, fullLen, guard;
    logic valid, ok;
    logic [1:0] expSt, gotSt;
    logic [15:0] expData, gotData, ind;
    logic eWr[6];
    logic [15:0] eAddr[6], eData[6];
    startIdx = txnIdx;
    errAbs   = (errRel < 0) ? -1 : startIdx + errRel;
    rdVal    = rv;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqPhy = phy; reqPage = pg;
    reqReg = rg; reqWdata = wd; reqFlush = fl;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 busy after accept", busy === 1'b1, busy, 1);
    if (midReq) begin
      @(negedge clk);
      reqValid = 1'b1; reqWrite = ~w; reqPhy = 5'd0; reqPage = 4'd0; reqReg = 6'd0;
      @(negedge clk);
      reqValid = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    check("R9 done reached", guard < 200, guard, 0);
    gotSt = respStatus; gotData = respData;
    @(negedge clk);
    check("R9 done one cycle, busy ends", done === 1'b0 && busy === 1'b0,
          {done, busy}, 0);
    // expected sequence
    valid = (phy <= 4) && (pg <= 7) && (rg <= 31);
    ind = 16'h8000 | (16'h1 << (9 + phy)) | (16'(pg) << 5) | 16'(rg);
    eWr[0] = 1; eAddr[0] = 16'h8028; eData[0] = w ? 16'h0 : 16'h1;
    eWr[1] = 1; eAddr[1] = ind;      eData[1] = w ? wd : 16'h0;
    eWr[2] = 0; eAddr[2] = 16'h8029; eData[2] = 0;
    if (w) begin
      eWr[2] = 1; eAddr[2] = 16'h8028; eData[2] = 16'h1;
    end
    eWr[3] = 1; eAddr[3] = ind;      eData[3] = 0;
    eWr[4] = 0; eAddr[4] = 16'h8029; eData[4] = 0;
    eWr[5] = 0; eAddr[5] = 0;        eData[5] = 0;
    mainLen = w ? 2 : 3;
    fullLen = (w && fl) ? 5 : mainLen;
    if (!valid) begin
      n = 0; expSt = 2'd1; expData = 16'hFFFF;
    end else if (errRel >= 0 && errRel < fullLen) begin
      n = errRel + 1;
      expSt = (errRel < mainLen) ? 2'd2 : 2'd0;
      expData = 16'hFFFF;
    end else begin
      n = fullLen; expSt = 2'd0; expData = w ? 16'hFFFF : rv;
    end
    check(valid ? "R7 R8 transaction count" : "R2 no traffic on reject",
          (txnIdx - startIdx) == n, txnIdx - startIdx, n);
    ok = 1'b1;
    for (int i = 0; i < n && i < 6; i++) begin
      int k;
      k = (startIdx + i) % 16;
      if (logWr[k] !== eWr[i] || logAddr[k] !== eAddr[i] ||
          (eWr[i] && logData[k] !== eData[i])) begin
        if (ok)
          $display("FAIL R3 R4 R5 R6 R8 txn %0d got=%0h/%0h/%0h exp=%0h/%0h/%0h", i,
                   logWr[k], logAddr[k], logData[k], eWr[i], eAddr[i], eData[i]);
        ok = 1'b0;
      end
    end
    tests++;
    if (!ok) fails++;
    check("R2 R5 R7 status", gotSt === expSt, gotSt, expSt);
    check("R5 R6 R7 data", gotData === expData, gotData, expData);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", busy === 0 && done === 0 && busReqValid === 0,
          {busy, done, busReqValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", busReqValid === 0 && txnIdx == 0, txnIdx, 0);
    // sweep fields, both directions (R2..R6)
    for (int phy = 0; phy <= 5; phy++)
      for (int pg = 0; pg <= 8; pg++)
        for (int rg = 0; rg <= 33; rg++) begin
          doOp(1'b0, 5'(phy), 4'(pg), 6'(rg), 16'h0, 1'b0, -1,
               16'(phy * 1237 + pg * 97 + rg * 3 + 16'h1000), 1'b0);
          doOp(1'b1, 5'(phy), 4'(pg), 6'(rg), 16'(16'hC000 ^ (rg * 515 + pg * 33 + phy)),
               1'b0, -1, 16'h0, 1'b0);
        end
    // out-of-range at the far end of each field (R2)
    doOp(1'b0, 5'd31, 4'd0, 6'd0, 16'h0, 1'b0, -1, 16'h1, 1'b0);
    doOp(1'b1, 5'd0, 4'd15, 6'd0, 16'h5, 1'b1, -1, 16'h1, 1'b0);
    doOp(1'b0, 5'd1, 4'd1, 6'd63, 16'h0, 1'b0, -1, 16'h1, 1'b0);
    // bus errors at every position (R7, R8), with latency (R10)
    lat = 3;
    for (int e = 0; e < 3; e++) doOp(1'b0, 5'd2, 4'd3, 6'd9, 16'h0, 1'b0, e, 16'h7777, 1'b0);
    for (int e = 0; e < 2; e++) doOp(1'b1, 5'd4, 4'd7, 6'd31, 16'hBEEF, 1'b0, e, 16'h0, 1'b0);
    for (int e = 0; e < 6; e++) doOp(1'b1, 5'd3, 4'd5, 6'd17, 16'h1234, 1'b1, e, 16'h4321, 1'b0);
    // flushed writes without error, several PHYs (R8)
    lat = 1;
    for (int p = 0; p <= 4; p++) doOp(1'b1, 5'(p), 4'(p), 6'(p * 6), 16'(p * 4099), 1'b1, -1,
                                      16'h55AA, 1'b0);
    // request raised while busy must be ignored (R9)
    lat = 2;
    doOp(1'b0, 5'd1, 4'd2, 6'd3, 16'h0, 1'b0, -1, 16'h2468, 1'b1);
    doOp(1'b1, 5'd4, 4'd6, 6'd30, 16'hA5A5, 1'b1, -1, 16'h0, 1'b1);
    repeat (10) @(negedge clk);
    check("R9 no activity after ignored request", busy === 0 && busReqValid === 0,
          {busy, busReqValid}, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule